// File: doc/BRIEF.md
# Sequence Completion Flag Register

This block keeps one completion flag for each conversion slot of a sequenced converter. The flags are numbered by the slot's position in the sequence. When the converter finishes the conversion for slot x, it sends a one-cycle completion pulse that carries the slot index and the result word. The block stores the result in result register x and sets flag x. Software reaches the block through a small register-select bus with a read strobe and a write strobe. Through it, software reads the flag register and the per-slot result registers. The bus also tells the block when software writes the sequence-start control register.

There are three ways to clear a flag, and the mode input decides which one applies:

- **Sequence start.** A write to the sequence-start register clears every flag. It beats a completion in the same cycle.
- **Normal mode.** Reading the flag register arms each flag that reads as 1. A later read of result register x clears flag x only if flag x was armed.
- **Fast-clear mode.** A read of result register x clears flag x directly.

A completion that arrives in the same cycle as either read-based clear wins, and the flag stays 1.

The converter side has no back-pressure. A completion pulse is accepted in the cycle it appears, so the block has no ready signal and never stalls the converter. Control and status pins are plain levels or one-cycle strobes.

Top module: `seqflag_top`

## Requirements
- R1: A completion pulse with slot index x sets flag x and latches the result word into result register x, from the next clock edge on.
- R2: After reset all flags are 0. A write with select code NSLOT, which addresses the flag register, changes no flag.
- R3: A write with select code NSLOT+1, the sequence-start register, clears all flags and all armed bits on the next edge.
- R4: In normal mode (fast_clr=0), a read of the flag register arms every flag that reads 1. A later read of result register x clears flag x if it is armed, and the read consumes the armed bit.
- R5: In normal mode, a result read does not clear flag x unless flag x was armed. This covers a flag that was not read as 1 by a status read, including a flag set after that status read.
- R6: In fast-clear mode (fast_clr=1), a read of result register x alone clears flag x.
- R7: When a sequence-start write and a completion for slot x fall in the same cycle, flag x ends up 0.
- R8: When a read-based clear of flag x (either mode) and a completion for slot x fall in the same cycle, flag x ends up 1.
- R9: Read data is combinational from the current select. Codes 0 to NSLOT-1 return that result register, code NSLOT returns the flags in bits NSLOT-1:0 (flag x in bit x), and all other codes return 0.
- R10: A flag never falls in a cycle that has neither a read strobe nor a sequence-start write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | SELW | Register select (0..NSLOT-1 results, NSLOT flags, NSLOT+1 start) |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rdata | output | DW | Read data for the selected register |
| cv_done | input | 1 | Conversion completion pulse |
| cv_slot | input | IDXW | Slot index of the completed conversion |
| cv_result | input | RW | Result word of the completed conversion |
| fast_clr | input | 1 | 1 selects fast-clear mode |
| flags_o | output | NSLOT | Current flag register contents |

## Verification
The bench builds the block with its defaults: NSLOT=8 and RW=10. That gives a 4-bit select, so the bench reaches every result slot, the flag and start codes, and the six unused codes 10 to 15 that must read as 0. With only eight slots, random completions often land on the same slot as a result read, a status read or a start write in the same cycle. That exercises both concurrent-priority rules many times, alongside directed cases for each clear route in both modes.

// File: rtl/seqflag_pkg.sv
package seqflag_pkg;
  // select code of the flag register
  function automatic int sel_flags(input int nslot);
    return nslot;
  endfunction
  // select code of the sequence-start control register
  function automatic int sel_start(input int nslot);
    return nslot + 1;
  endfunction
  // decoded bus access kinds shared by the decode stage
  typedef struct packed {
    logic start;
    logic rd_stat;
  } bus_evt_t;
endpackage

// File: rtl/seqflag_decode.sv
module seqflag_decode #(
  parameter int NSLOT = 8,
  parameter int SELW  = 4,
  parameter int IDXW  = 3
) (
  input  logic [SELW-1:0]  bus_sel,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic             cv_done,
  input  logic [IDXW-1:0]  cv_slot,
  output seqflag_pkg::bus_evt_t evt,
  output logic [NSLOT-1:0] rd_res,
  output logic [NSLOT-1:0] set_slot
);
  localparam logic [SELW-1:0] SelFlags = SELW'(seqflag_pkg::sel_flags(NSLOT));
  localparam logic [SELW-1:0] SelStart = SELW'(seqflag_pkg::sel_start(NSLOT));

  always_comb begin
    evt.start   = bus_wr && (bus_sel == SelStart);
    evt.rd_stat = bus_rd && (bus_sel == SelFlags);
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_dec
    assign rd_res[i]   = bus_rd && (bus_sel == SELW'(i));
    assign set_slot[i] = cv_done && (cv_slot == IDXW'(i));
  end
endmodule

// File: rtl/seqflag_cell.sv
module seqflag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic start_i,
  input  logic rd_stat_i,
  input  logic rd_res_i,
  input  logic fast_clr,
  output logic flag_o
);
  logic armed_q;
  logic flag_q;
  logic rd_clr;

  // a result read clears directly in fast mode, or only when armed otherwise
  assign rd_clr = rd_res_i && (fast_clr || armed_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (start_i) begin
      armed_q <= 1'b0;
    end else if (rd_stat_i && !fast_clr) begin
      armed_q <= flag_q;
    end else if (rd_res_i) begin
      armed_q <= 1'b0;
    end
  end

  // priority: start clear > set > read-based clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (start_i) begin
      flag_q <= 1'b0;
    end else if (set_i) begin
      flag_q <= 1'b1;
    end else if (rd_clr) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/seqflag_results.sv
module seqflag_results #(
  parameter int NSLOT = 8,
  parameter int RW    = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSLOT-1:0]   set_slot,
  input  logic [RW-1:0]      cv_result,
  output logic [NSLOT*RW-1:0] res_flat
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_res
    logic [RW-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (set_slot[i]) begin
        word_q <= cv_result;
      end
    end
    assign res_flat[i*RW +: RW] = word_q;
  end
endmodule

// File: rtl/seqflag_rdmux.sv
module seqflag_rdmux #(
  parameter int NSLOT = 8,
  parameter int RW    = 10,
  parameter int SELW  = 4,
  parameter int DW    = 10
) (
  input  logic [SELW-1:0]     bus_sel,
  input  logic [NSLOT-1:0]    flags,
  input  logic [NSLOT*RW-1:0] res_flat,
  output logic [DW-1:0]       rdata
);
  localparam logic [SELW-1:0] SelFlags = SELW'(seqflag_pkg::sel_flags(NSLOT));

  always_comb begin
    rdata = '0;
    if (bus_sel == SelFlags) begin
      rdata = DW'(flags);
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (bus_sel == SELW'(i)) rdata = DW'(res_flat[i*RW +: RW]);
      end
    end
  end
endmodule

// File: rtl/seqflag_top.sv
module seqflag_top #(
  parameter int NSLOT = 8,
  parameter int RW    = 10,
  localparam int SELW = $clog2(NSLOT + 2),
  localparam int IDXW = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int DW   = (RW > NSLOT) ? RW : NSLOT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SELW-1:0]  bus_sel,
  input  logic             bus_rd,
  input  logic             bus_wr,
  output logic [DW-1:0]    bus_rdata,
  input  logic             cv_done,
  input  logic [IDXW-1:0]  cv_slot,
  input  logic [RW-1:0]    cv_result,
  input  logic             fast_clr,
  output logic [NSLOT-1:0] flags_o
);
  seqflag_pkg::bus_evt_t evt;
  logic [NSLOT-1:0]    rd_res;
  logic [NSLOT-1:0]    set_slot;
  logic [NSLOT*RW-1:0] res_flat;

  seqflag_decode #(.NSLOT(NSLOT), .SELW(SELW), .IDXW(IDXW)) u_dec (
    .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .cv_done(cv_done), .cv_slot(cv_slot),
    .evt(evt), .rd_res(rd_res), .set_slot(set_slot)
  );

  for (genvar i = 0; i < NSLOT; i++) begin : g_cell
    seqflag_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_slot[i]), .start_i(evt.start),
      .rd_stat_i(evt.rd_stat), .rd_res_i(rd_res[i]),
      .fast_clr(fast_clr), .flag_o(flags_o[i])
    );
  end

  seqflag_results #(.NSLOT(NSLOT), .RW(RW)) u_res (
    .clk(clk), .rst_n(rst_n), .set_slot(set_slot),
    .cv_result(cv_result), .res_flat(res_flat)
  );

  seqflag_rdmux #(.NSLOT(NSLOT), .RW(RW), .SELW(SELW), .DW(DW)) u_mux (
    .bus_sel(bus_sel), .flags(flags_o), .res_flat(res_flat), .rdata(bus_rdata)
  );
endmodule

// File: rtl/seqflag_chk.sv
module seqflag_chk #(
  parameter int NSLOT = 8,
  parameter int SELW  = 4,
  parameter int IDXW  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SELW-1:0]  bus_sel,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic             cv_done,
  input logic [IDXW-1:0]  cv_slot,
  input logic             fast_clr,
  input logic [NSLOT-1:0] flags_o
);
  logic wr_start;
  logic wr_flags;
  logic rd_result;
  assign wr_start  = bus_wr && (bus_sel == SELW'(NSLOT + 1));
  assign wr_flags  = bus_wr && (bus_sel == SELW'(NSLOT));
  assign rd_result = bus_rd && (bus_sel < SELW'(NSLOT));

  p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> (flags_o == '0));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_done && !wr_start) |=> flags_o[$past(cv_slot)]);

  p_fast_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_result && fast_clr && !(cv_done && (cv_slot == bus_sel[IDXW-1:0])))
      |=> !flags_o[$past(bus_sel[IDXW-1:0])]);

  p_ro_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flags && !cv_done && !bus_rd) |=> $stable(flags_o));

  p_no_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && !wr_start) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
endmodule

bind seqflag_top seqflag_chk #(.NSLOT(NSLOT), .SELW(SELW), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .cv_done(cv_done), .cv_slot(cv_slot), .fast_clr(fast_clr), .flags_o(flags_o)
);

// File: tb/seqflag_top_bench.sv
module seqflag_top_bench;
  localparam int NSLOT = 8;
  localparam int RW    = 10;
  localparam int SELW  = 4;
  localparam int IDXW  = 3;
  localparam int DW    = 10;
  localparam int SFLG  = NSLOT;
  localparam int SSTA  = NSLOT + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SELW-1:0] bus_sel = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0, cv_done = 1'b0, fast_clr = 1'b0;
  logic [IDXW-1:0] cv_slot = '0;
  logic [RW-1:0] cv_result = '0;
  logic [DW-1:0] bus_rdata;
  logic [NSLOT-1:0] flags_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [NSLOT-1:0] m_flag = '0;
  logic [NSLOT-1:0] m_arm = '0;
  logic [RW-1:0] m_res [NSLOT];

  always #4 clk = ~clk;

  seqflag_top u_seqflag_top (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .cv_done(cv_done), .cv_slot(cv_slot),
    .cv_result(cv_result), .fast_clr(fast_clr), .flags_o(flags_o)
  );

  function automatic logic [DW-1:0] exp_rdata(input logic [SELW-1:0] s);
    if (s < SELW'(NSLOT)) return DW'(m_res[s[IDXW-1:0]]);
    if (s == SELW'(SFLG)) return DW'(m_flag);
    return '0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one bus/converter cycle; model follows the requirements
  task automatic cyc(input string tag, input logic rd, input logic wr, input int sel,
                     input logic dn, input int slot, input logic [RW-1:0] val, input logic fc);
    logic st, rs;
    logic [NSLOT-1:0] nf, na;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_sel = SELW'(sel);
    cv_done = dn; cv_slot = IDXW'(slot); cv_result = val; fast_clr = fc;
    #1;
    if (rd) check({tag, " R9 rdata"}, 32'(bus_rdata), 32'(exp_rdata(SELW'(sel))));
    @(posedge clk);
    st = wr && (sel == SSTA);
    rs = rd && (sel == SFLG);
    for (int i = 0; i < NSLOT; i++) begin
      logic setx, rrx;
      setx = dn && (slot == i);
      rrx  = rd && (sel == i);
      na[i] = st ? 1'b0 : (rs && !fc) ? m_flag[i] : rrx ? 1'b0 : m_arm[i];
      nf[i] = st ? 1'b0 : setx ? 1'b1 : (rrx && (fc || m_arm[i])) ? 1'b0 : m_flag[i];
      if (setx) m_res[i] = val;
    end
    m_flag = nf; m_arm = na;
    #1;
    check({tag, " R10 flags"}, 32'(flags_o), 32'(m_flag));
    bus_rd = 1'b0; bus_wr = 1'b0; cv_done = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NSLOT; i++) m_res[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R2 reset flags", 32'(flags_o), 32'h0);
    @(negedge clk); rst_n = 1'b1;

    cyc("R1 set3", 0, 0, 0, 1, 3, 10'h2a5, 0);
    check("R1 flag3 set", 32'(flags_o[3]), 32'h1);
    cyc("R1 read res3", 1, 0, 3, 0, 0, '0, 0);
    check("R5 unarmed read keeps flag3", 32'(flags_o[3]), 32'h1);
    cyc("R4 status read", 1, 0, SFLG, 0, 0, '0, 0);
    cyc("R4 result read", 1, 0, 3, 0, 0, '0, 0);
    check("R4 flag3 cleared", 32'(flags_o[3]), 32'h0);
    cyc("R5 status read flag2=0", 1, 0, SFLG, 0, 0, '0, 0);
    cyc("R5 set2 after status", 0, 0, 0, 1, 2, 10'h111, 0);
    cyc("R5 read res2", 1, 0, 2, 0, 0, '0, 0);
    check("R5 late flag2 kept", 32'(flags_o[2]), 32'h1);
    cyc("R2 write flag reg", 0, 1, SFLG, 0, 0, '0, 0);
    check("R2 write no effect", 32'(flags_o), 32'h4);
    cyc("R3 start write", 0, 1, SSTA, 0, 0, '0, 0);
    check("R3 all cleared", 32'(flags_o), 32'h0);
    cyc("R7 start with set", 0, 1, SSTA, 1, 4, 10'h0f0, 0);
    check("R7 start wins", 32'(flags_o[4]), 32'h0);
    cyc("R6 set5", 0, 0, 0, 1, 5, 10'h3ff, 1);
    cyc("R6 fast read res5", 1, 0, 5, 0, 0, '0, 1);
    check("R6 flag5 cleared", 32'(flags_o[5]), 32'h0);
    cyc("R8 set6", 0, 0, 0, 1, 6, 10'h001, 1);
    cyc("R8 fast read+set6", 1, 0, 6, 1, 6, 10'h002, 1);
    check("R8 fast set wins", 32'(flags_o[6]), 32'h1);
    cyc("R8 set1", 0, 0, 0, 1, 1, 10'h055, 0);
    cyc("R8 status arm1", 1, 0, SFLG, 0, 0, '0, 0);
    cyc("R8 normal read+set1", 1, 0, 1, 1, 1, 10'h056, 0);
    check("R8 normal set wins", 32'(flags_o[1]), 32'h1);
    cyc("R9 unused sel", 1, 0, 12, 0, 0, '0, 0);
    check("R9 unused reads 0", 32'(bus_rdata), 32'h0);

    for (int n = 0; n < 3000; n++) begin
      int r, sel;
      r = int'($urandom_range(0, 99));
      sel = (r < 10) ? SSTA : (r < 35) ? SFLG : int'($urandom_range(0, 15));
      cyc("rand", $urandom_range(0, 2) != 0, r < 12, sel,
          $urandom_range(0, 2) == 0, int'($urandom_range(0, NSLOT - 1)),
          RW'($urandom), n >= 1500);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule